// File: doc/BRIEF.md
# Byte-Serializing Bus Width Bridge

This block sits between a 32-bit master port that carries byte enables and a set of 8-bit slave ports. Each accepted master access is broken into single-byte accesses to consecutive byte addresses. The block issues them one at a time, and every byte goes to whichever slave window its own address falls in. There are three 16-byte I/O windows, and each has its own read and write strobes. The I/O windows share one 4-bit offset bus and one write-data byte. A fourth window is a 128 KiB memory region with a 17-bit offset.

On a read, each returned byte is placed back in the lane it came from before the master sees completion. While the sequence runs, the master is held off by a stall signal. Completion is a single-cycle done pulse, and the error flag rides on that pulse. After every transaction the bridge rests for a fixed number of idle cycles before it accepts the next access.

Top module: `wide_to_byte_bridge`

## Requirements
- R1: The byte enables must form one contiguous run of set bits. The legal values are 0x1, 0x2, 0x3, 0x4, 0x6, 0x7, 0x8, 0xC, 0xE and 0xF. The values 0x0, 0x5, 0x9, 0xA, 0xB and 0xD are rejected: the access completes with `m_err`=1 and no slave strobe is raised.
- R2: The low two bits of `m_addr` are ignored. The first byte address is the word address plus the index of the lowest enabled lane. Exactly as many byte accesses are made as there are set enable bits, at rising byte addresses.
- R3: Byte addresses 0x3B0–0x3BF use I/O port 0, 0x3C0–0x3CF use port 1 and 0x3D0–0x3DF use port 2. The port strobes are bits 0, 1 and 2 of `io_rd`/`io_wr`, and `io_addr` carries the low 4 address bits. The window is decoded again for every byte.
- R4: Byte addresses 0xA0000–0xBFFFF use the memory port, and `mem_addr` carries the low 17 address bits.
- R5: A start address outside all four windows completes with `m_err`=1 and makes no slave access.
- R6: Each strobe is high for exactly one cycle. The cycle after it has every strobe low, so strobes of consecutive bytes are two cycles apart. Read data is taken from the slave in the cycle after its strobe.
- R7: On a write, the first byte sent is from the lowest enabled lane of `m_wdata`, and each later byte comes from the next higher lane.
- R8: On a read, each byte lands in `m_rdata` in the lane it was addressed through. Lanes that are not enabled read as zero.
- R9: For an access of n bytes accepted in cycle 0, `m_done` pulses for one cycle in cycle 2n+1. A rejected access pulses `m_done` in cycle 1. `m_err` is high only together with `m_done`.
- R10: `m_stall` is high from the cycle after acceptance until 5 cycles after the done pulse. A new access is accepted in the first cycle that `m_stall` is low.
- R11: At most one slave strobe is high in any cycle. All strobes are low during reset and while the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | 32 | Master byte address (low 2 bits ignored) |
| m_be | input | 4 | Master byte enables |
| m_wdata | input | 32 | Master write data |
| m_read | input | 1 | Master read request, sampled while `m_stall` is low |
| m_write | input | 1 | Master write request, sampled while `m_stall` is low |
| m_stall | output | 1 | Bridge busy; requests are not taken |
| m_done | output | 1 | One-cycle completion pulse |
| m_err | output | 1 | Access rejected, valid with `m_done` |
| m_rdata | output | 32 | Reassembled read data, valid with `m_done` |
| io_addr | output | 4 | Offset within the selected I/O window |
| io_rd | output | 3 | Per-port I/O read strobes |
| io_wr | output | 3 | Per-port I/O write strobes |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 24 | I/O read bytes, port k on bits 8k+7:8k |
| mem_addr | output | 17 | Offset within the memory window |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |

## Verification
A wrong lane counter or remaining-byte count shows up at the slave ports within one byte slot. It appears as a wrong `io_addr`/`mem_addr`, an extra strobe or a missing strobe. It also moves the done pulse away from cycle 2n+1, and the bench measures that cycle exactly. A wrong sequencer state shows up as strobes closer than two cycles apart, as a strobe on the wrong port, or as the stall dropping before the 5-cycle rest ends. An error in the read packer only shows up at `m_done`, as a byte in the wrong lane or a nonzero disabled lane. That is why every legal enable pattern is read back against known slave contents.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_SAMPLE,
    ST_DONE,
    ST_GAP
  } bb_state_e;
endpackage

// File: rtl/bb_lane_check.sv
module bb_lane_check #(
  parameter int NLANE = 4,
  localparam int LW = $clog2(NLANE),
  localparam int CW = $clog2(NLANE + 1)
) (
  input  logic [NLANE-1:0] be,
  output logic             legal,
  output logic [LW-1:0]    first,
  output logic [CW-1:0]    count
);
  logic             found;
  logic [NLANE-1:0] run;

  // lowest enabled lane and number of enabled lanes
  always_comb begin
    first = '0;
    count = '0;
    found = 1'b0;
    for (int i = 0; i < NLANE; i++) begin
      if (be[i]) begin
        count = count + CW'(1);
        if (!found) first = LW'(i);
        found = 1'b1;
      end
    end
  end

  // the one contiguous run those two values describe
  always_comb begin
    run = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (i >= int'(first) && i < int'(first) + int'(count)) run[i] = 1'b1;
    end
    legal = found && (run == be);
  end
endmodule

// File: rtl/bb_win_decode.sv
module bb_win_decode #(
  parameter int              AW        = 32,
  parameter int              NIO       = 3,
  parameter int              IO_SPAN_W = 4,
  parameter logic [AW-1:0]   IO_BASE   = 'h3B0,
  parameter int              MEM_AW    = 17,
  parameter logic [AW-1:0]   MEM_BASE  = 'hA0000
) (
  input  logic [AW-1:0]        baddr,
  output logic [NIO-1:0]       io_hit,
  output logic                 mem_hit,
  output logic                 any_hit,
  output logic [IO_SPAN_W-1:0] io_off,
  output logic [MEM_AW-1:0]    mem_off
);
  localparam int IO_SPAN = 2 ** IO_SPAN_W;

  for (genvar g = 0; g < NIO; g++) begin : g_io_win
    localparam logic [AW-1:0] WBASE = AW'(IO_BASE + AW'(g * IO_SPAN));
    assign io_hit[g] = (baddr[AW-1:IO_SPAN_W] == WBASE[AW-1:IO_SPAN_W]);
  end

  assign mem_hit = (baddr[AW-1:MEM_AW] == MEM_BASE[AW-1:MEM_AW]);
  assign any_hit = mem_hit | (|io_hit);
  assign io_off  = baddr[IO_SPAN_W-1:0];
  assign mem_off = baddr[MEM_AW-1:0];
endmodule

// File: rtl/bb_rd_pack.sv
module bb_rd_pack #(
  parameter int NLANE = 4,
  localparam int LW = $clog2(NLANE),
  localparam int DW = 8 * NLANE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [LW-1:0] lane,
  input  logic [7:0]    byte_in,
  output logic [DW-1:0] merged
);
  logic [DW-1:0] acc;

  always_comb begin
    merged = acc;
    if (load) merged[{lane, 3'b000} +: 8] = byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else              acc <= merged;
  end
endmodule

// File: rtl/wide_to_byte_bridge.sv
module wide_to_byte_bridge
  import bb_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            DW         = 32,
  parameter int            NIO        = 3,
  parameter int            IO_SPAN_W  = 4,
  parameter logic [AW-1:0] IO_BASE    = 'h3B0,
  parameter int            MEM_AW     = 17,
  parameter logic [AW-1:0] MEM_BASE   = 'hA0000,
  parameter int            GAP_CYCLES = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        m_addr,
  input  logic [DW/8-1:0]      m_be,
  input  logic [DW-1:0]        m_wdata,
  input  logic                 m_read,
  input  logic                 m_write,
  output logic                 m_stall,
  output logic                 m_done,
  output logic                 m_err,
  output logic [DW-1:0]        m_rdata,
  output logic [IO_SPAN_W-1:0] io_addr,
  output logic [NIO-1:0]       io_rd,
  output logic [NIO-1:0]       io_wr,
  output logic [7:0]           io_wdata,
  input  logic [NIO*8-1:0]     io_rdata,
  output logic [MEM_AW-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [7:0]           mem_wdata,
  input  logic [7:0]           mem_rdata
);
  localparam int NLANE = DW / 8;
  localparam int LW    = $clog2(NLANE);
  localparam int CW    = $clog2(NLANE + 1);
  localparam int GW    = $clog2(GAP_CYCLES + 1);

  bb_state_e state;

  logic [AW-1:0]   cur_addr;
  logic [CW-1:0]   left;
  logic [LW-1:0]   lane;
  logic            is_wr;
  logic [DW-1:0]   wdata_q;
  logic [NIO-1:0]  tgt_io;
  logic            tgt_mem;
  logic [GW-1:0]   gap_cnt;
  logic [7:0]      byte_q;

  logic            be_ok;
  logic [LW-1:0]   be_first;
  logic [CW-1:0]   be_count;

  logic [AW-1:0]   nxt_addr;
  logic [LW-1:0]   nxt_lane;
  logic [DW-1:0]   src_word;
  logic [7:0]      nxt_byte;
  logic            wr_sel;
  logic [NIO-1:0]  nxt_io_hit;
  logic            nxt_mem_hit;
  logic            nxt_any_hit;
  logic [IO_SPAN_W-1:0] nxt_io_off;
  logic [MEM_AW-1:0]    nxt_mem_off;

  logic [7:0]      rbyte;
  logic [DW-1:0]   merged;
  logic            req;
  logic            is_idle;
  logic            any_strobe;

  assign req        = m_read | m_write;
  assign is_idle    = (state == ST_IDLE);
  assign any_strobe = (|io_rd) | (|io_wr) | mem_rd | mem_wr;
  assign m_stall    = !is_idle;
  assign io_wdata   = byte_q;
  assign mem_wdata  = byte_q;

  bb_lane_check #(.NLANE(NLANE)) u_lane_check (
    .be    (m_be),
    .legal (be_ok),
    .first (be_first),
    .count (be_count)
  );

  // address, lane and data of the byte about to be launched
  always_comb begin
    if (is_idle) begin
      nxt_addr = (m_addr & ~AW'(NLANE - 1)) + AW'(be_first);
      nxt_lane = be_first;
      src_word = m_wdata;
      wr_sel   = m_write;
    end else begin
      nxt_addr = cur_addr + AW'(1);
      nxt_lane = lane + LW'(1);
      src_word = wdata_q;
      wr_sel   = is_wr;
    end
    nxt_byte = src_word[{nxt_lane, 3'b000} +: 8];
  end

  bb_win_decode #(
    .AW(AW), .NIO(NIO), .IO_SPAN_W(IO_SPAN_W), .IO_BASE(IO_BASE),
    .MEM_AW(MEM_AW), .MEM_BASE(MEM_BASE)
  ) u_win_decode (
    .baddr   (nxt_addr),
    .io_hit  (nxt_io_hit),
    .mem_hit (nxt_mem_hit),
    .any_hit (nxt_any_hit),
    .io_off  (nxt_io_off),
    .mem_off (nxt_mem_off)
  );

  // byte returned by the port addressed in the previous strobe cycle
  always_comb begin
    rbyte = tgt_mem ? mem_rdata : 8'h00;
    for (int i = 0; i < NIO; i++) begin
      if (tgt_io[i]) rbyte = rbyte | io_rdata[i*8 +: 8];
    end
  end

  bb_rd_pack #(.NLANE(NLANE)) u_rd_pack (
    .clk     (clk),
    .rst     (rst),
    .clear   (is_idle),
    .load    ((state == ST_SAMPLE) && !is_wr),
    .lane    (lane),
    .byte_in (rbyte),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      left     <= '0;
      lane     <= '0;
      is_wr    <= 1'b0;
      wdata_q  <= '0;
      tgt_io   <= '0;
      tgt_mem  <= 1'b0;
      gap_cnt  <= '0;
      byte_q   <= '0;
      io_addr  <= '0;
      mem_addr <= '0;
      io_rd    <= '0;
      io_wr    <= '0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      m_done   <= 1'b0;
      m_err    <= 1'b0;
      m_rdata  <= '0;
    end else begin
      io_rd  <= '0;
      io_wr  <= '0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      m_done <= 1'b0;
      m_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            is_wr   <= m_write;
            wdata_q <= m_wdata;
            if (!be_ok || !nxt_any_hit) begin
              m_done  <= 1'b1;
              m_err   <= 1'b1;
              m_rdata <= '0;
              state   <= ST_DONE;
            end else begin
              left  <= be_count;
              state <= ST_STROBE;
            end
          end
        end
        ST_STROBE: state <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (left > CW'(1)) begin
            left  <= left - CW'(1);
            state <= ST_STROBE;
          end else begin
            m_done  <= 1'b1;
            m_rdata <= is_wr ? '0 : merged;
            state   <= ST_DONE;
          end
        end
        ST_DONE: begin
          gap_cnt <= GW'(GAP_CYCLES - 1);
          state   <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_cnt == '0) state <= ST_IDLE;
          else               gap_cnt <= gap_cnt - GW'(1);
        end
        default: state <= ST_IDLE;
      endcase

      // launch one byte: first byte from idle, later bytes after a sample slot
      if ((is_idle && req && be_ok && nxt_any_hit) ||
          (state == ST_SAMPLE && left > CW'(1))) begin
        cur_addr <= nxt_addr;
        lane     <= nxt_lane;
        byte_q   <= nxt_byte;
        io_addr  <= nxt_io_off;
        mem_addr <= nxt_mem_off;
        tgt_io   <= nxt_io_hit;
        tgt_mem  <= nxt_mem_hit;
        io_rd    <= nxt_io_hit & {NIO{!wr_sel}};
        io_wr    <= nxt_io_hit & {NIO{wr_sel}};
        mem_rd   <= nxt_mem_hit & !wr_sel;
        mem_wr   <= nxt_mem_hit & wr_sel;
      end
    end
  end

  // strobe discipline (R11)
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({io_rd, io_wr, mem_rd, mem_wr}));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    is_idle |-> !any_strobe);
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> !any_strobe);
  // one idle strobe cycle between bytes (R6)
  p_strobe_gap_r6: assert property (@(posedge clk) disable iff (rst)
    any_strobe |=> !any_strobe);
  // completion handshake (R9) and rest period (R10)
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    m_done |=> !m_done);
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    m_err |-> m_done);
  p_gap_stall_r10: assert property (@(posedge clk) disable iff (rst)
    m_done |=> m_stall);
  // rejected accesses never reach a slave (R1, R5)
  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (is_idle && req && !(be_ok && nxt_any_hit)) |=> !any_strobe);
endmodule

// File: tb/wide_to_byte_bridge_bench.sv
module wide_to_byte_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] m_addr = '0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_wdata = '0;
  logic        m_read = 1'b0;
  logic        m_write = 1'b0;
  logic        m_stall, m_done, m_err;
  logic [31:0] m_rdata;
  logic [3:0]  io_addr;
  logic [2:0]  io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic [23:0] io_rdata = '0;
  logic [16:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] io_regs [3][16];
  logic [7:0] mem_model [256];

  int          ev_n = 0;
  int          ev_port [64];
  logic [16:0] ev_addr [64];
  logic        ev_wr   [64];
  logic [7:0]  ev_data [64];
  int          ev_cyc  [64];

  always #5 clk = ~clk;

  wide_to_byte_bridge u_wide_to_byte_bridge (
    .clk(clk), .rst(rst),
    .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata),
    .m_read(m_read), .m_write(m_write),
    .m_stall(m_stall), .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // slave models with registered read data, plus a strobe log
  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int p = 0; p < 3; p++) begin
      if (io_rd[p]) io_rdata[p*8 +: 8] <= io_regs[p][io_addr];
      if (io_wr[p]) io_regs[p][io_addr] <= io_wdata;
      if ((io_rd[p] || io_wr[p]) && ev_n < 64) begin
        ev_port[ev_n] = p;
        ev_addr[ev_n] = {13'd0, io_addr};
        ev_wr[ev_n]   = io_wr[p];
        ev_data[ev_n] = io_wr[p] ? io_wdata : 8'h00;
        ev_cyc[ev_n]  = cyc;
        ev_n = ev_n + 1;
      end
    end
    if (mem_rd) mem_rdata <= mem_model[mem_addr[7:0]];
    if (mem_wr) mem_model[mem_addr[7:0]] <= mem_wdata;
    if ((mem_rd || mem_wr) && ev_n < 64) begin
      ev_port[ev_n] = 3;
      ev_addr[ev_n] = mem_addr;
      ev_wr[ev_n]   = mem_wr;
      ev_data[ev_n] = mem_wr ? mem_wdata : 8'h00;
      ev_cyc[ev_n]  = cyc;
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [3:0] b);
    return int'(b[0]) + int'(b[1]) + int'(b[2]) + int'(b[3]);
  endfunction

  function automatic int lowest(input logic [3:0] b);
    for (int i = 0; i < 4; i++) if (b[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] b);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (b[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  // one master access; returns data, error flag, accept-to-done latency, strobe count
  task automatic access(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output logic err,
                        output int lat, output int nev, output int e0);
    int c0;
    @(negedge clk);
    while (m_stall) @(negedge clk);
    m_addr = addr; m_be = be; m_wdata = wd;
    m_read = !wr; m_write = wr;
    c0 = cyc; e0 = ev_n;
    @(negedge clk);
    m_read = 1'b0; m_write = 1'b0;
    while (!m_done && (cyc - c0) < 100) @(negedge clk);
    rd = m_rdata; err = m_err; lat = cyc - c0;
    @(negedge clk);
    nev = ev_n - e0;
  endtask

  // stall must stay high for 5 more cycles after the done pulse (R10)
  task automatic check_gap(input string tag);
    int n = 1;
    while (m_stall && n < 20) begin
      @(negedge clk);
      if (m_stall) n++;
    end
    chk(n == 5, tag, 32'(n), 32'd5);
  endtask

  task automatic t_reset;
    chk(!m_stall, "R10 reset stall", {31'd0, m_stall}, 32'd0);
    chk(!m_done && !m_err, "R9 reset done", {30'd0, m_done, m_err}, 32'd0);
    chk({io_rd, io_wr, mem_rd, mem_wr} == 8'd0, "R11 reset strobes",
        {24'd0, io_rd, io_wr, mem_rd, mem_wr}, 32'd0);
  endtask

  task automatic t_io_write_read;
    logic [31:0] rd; logic err; int lat, nev, e0;
    access(1'b1, 32'h3C4, 4'hF, 32'h44332211, rd, err, lat, nev, e0);
    chk(!err, "R3 write err", {31'd0, err}, 32'd0);
    chk(nev == 4, "R2 write strobes", 32'(nev), 32'd4);
    chk(lat == 9, "R9 write latency", 32'(lat), 32'd9);
    for (int k = 0; k < 4 && k < nev; k++) begin
      chk(ev_port[e0+k] == 1 && ev_wr[e0+k], "R3 write port", 32'(ev_port[e0+k]), 32'd1);
      chk(ev_addr[e0+k] == 17'(4 + k), "R3 write io_addr", 32'(ev_addr[e0+k]), 32'(4 + k));
      chk(ev_data[e0+k] == 8'(8'h11 * (k + 1)), "R7 write byte order",
          32'(ev_data[e0+k]), 32'(8'h11 * (k + 1)));
      if (k > 0)
        chk(ev_cyc[e0+k] - ev_cyc[e0+k-1] == 2, "R6 strobe spacing",
            32'(ev_cyc[e0+k] - ev_cyc[e0+k-1]), 32'd2);
    end
    check_gap("R10 gap after write");
    access(1'b0, 32'h3C6, 4'hF, 32'h0, rd, err, lat, nev, e0);
    chk(rd == 32'h44332211, "R8 full read back", rd, 32'h44332211);
  endtask

  task automatic t_io_read_partial;
    logic [31:0] rd; logic err; int lat, nev, e0;
    access(1'b0, 32'h3B8, 4'h6, 32'h0, rd, err, lat, nev, e0);
    chk(rd == 32'h004A4900, "R8 partial read lanes", rd, 32'h004A4900);
    chk(nev == 2 && ev_addr[e0] == 17'd9 && ev_port[e0] == 0, "R2 partial start",
        32'(ev_addr[e0]), 32'd9);
    chk(lat == 5, "R9 partial latency", 32'(lat), 32'd5);
    access(1'b0, 32'h3D0, 4'h1, 32'h0, rd, err, lat, nev, e0);
    chk(rd == 32'h00000060 && ev_port[e0] == 2, "R3 port 2 read", rd, 32'h60);
  endtask

  task automatic t_mem;
    logic [31:0] rd; logic err; int lat, nev, e0;
    access(1'b1, 32'hA0120, 4'hC, 32'hBBAA9988, rd, err, lat, nev, e0);
    chk(nev == 2 && ev_port[e0] == 3 && ev_addr[e0] == 17'h00122, "R4 mem write addr",
        32'(ev_addr[e0]), 32'h122);
    chk(ev_data[e0] == 8'hAA && ev_data[e0+1] == 8'hBB, "R7 mem write bytes",
        {16'd0, ev_data[e0], ev_data[e0+1]}, 32'hAABB);
    access(1'b0, 32'hA0120, 4'hC, 32'h0, rd, err, lat, nev, e0);
    chk(rd == 32'hBBAA0000, "R8 mem read back", rd, 32'hBBAA0000);
    access(1'b0, 32'hBFFFE, 4'h8, 32'h0, rd, err, lat, nev, e0);
    chk(rd == 32'hA5000000 && ev_addr[e0] == 17'h1FFFF, "R4 mem top byte", rd, 32'hA5000000);
  endtask

  task automatic t_legal_all;
    logic [3:0] pats [10] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'hC, 4'hE, 4'hF};
    logic [31:0] rd; logic err; int lat, nev, e0;
    for (int k = 0; k < 10; k++) begin
      access(1'b0, 32'h3D4, pats[k], 32'h0, rd, err, lat, nev, e0);
      chk(!err, "R1 legal pattern accepted", {31'd0, err}, 32'd0);
      chk(rd == (32'h67666564 & lane_mask(pats[k])), "R8 lane pattern read",
          rd, 32'h67666564 & lane_mask(pats[k]));
      chk(nev == popc(pats[k]), "R2 byte count", 32'(nev), 32'(popc(pats[k])));
      chk(ev_addr[e0] == 17'(4 + lowest(pats[k])), "R2 first byte address",
          32'(ev_addr[e0]), 32'(4 + lowest(pats[k])));
      chk(lat == 2 * popc(pats[k]) + 1, "R9 done cycle", 32'(lat), 32'(2 * popc(pats[k]) + 1));
    end
  endtask

  task automatic t_illegal;
    logic [3:0] bad [6] = '{4'h0, 4'h5, 4'h9, 4'hA, 4'hB, 4'hD};
    logic [31:0] rd; logic err; int lat, nev, e0;
    for (int k = 0; k < 6; k++) begin
      access(1'b1, 32'h3D4, bad[k], 32'hFFFFFFFF, rd, err, lat, nev, e0);
      chk(err, "R1 illegal enables flagged", {31'd0, err}, 32'd1);
      chk(nev == 0, "R1 illegal enables no access", 32'(nev), 32'd0);
      chk(lat == 1, "R9 reject latency", 32'(lat), 32'd1);
      check_gap("R10 gap after reject");
    end
    access(1'b0, 32'h3D4, 4'hF, 32'h0, rd, err, lat, nev, e0);
    chk(rd == 32'h67666564, "R1 target untouched", rd, 32'h67666564);
  endtask

  task automatic t_outside;
    logic [31:0] addrs [4] = '{32'h3E0, 32'h3AC, 32'h9FFFC, 32'hC0000};
    logic [31:0] rd; logic err; int lat, nev, e0;
    for (int k = 0; k < 4; k++) begin
      access(1'b0, addrs[k], 4'hF, 32'h0, rd, err, lat, nev, e0);
      chk(err && nev == 0, "R5 outside window rejected", {31'd0, err}, 32'd1);
      chk(rd == 32'h0, "R5 outside window data", rd, 32'h0);
    end
  endtask

  initial begin
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 16; a++) io_regs[p][a] = 8'((p << 4) | a) + 8'h40;
    for (int i = 0; i < 256; i++) mem_model[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_io_write_read();
    t_io_read_partial();
    t_mem();
    t_legal_all();
    t_illegal();
    t_outside();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule